// File: doc/BRIEF.md
# Synchronous Burst Static RAM Model

This block is a cycle-accurate, synthesizable model of a synchronous burst static RAM with a small internal array. Every control and data input is captured on the rising clock edge. This includes the address, three chip enables, two address strobes, burst advance, per-lane byte enables, the byte-write enable and the global write. A cycle is started by one of the two strobes. The processor strobe can only start reads and is masked by the first chip enable. The controller strobe can start reads or writes. Later cycles continue or suspend a 2-bit burst that wraps within an aligned group of four words. The group is walked in linear or interleaved order.

Read data leaves through a data bus with a separate driver-enable signal, which stands in for a tri-state bus. In pipelined mode the data passes through one extra output register. In flow-through mode that register is bypassed. An asynchronous output-enable input can only switch the drivers off. A sleep input stops the device two clocks after it is raised. While asleep, all other inputs are ignored and the contents are kept. After wake-up, a recovery interval of a parameterised length follows. During recovery, write requests are dropped and reported.

Top module: `sbsram_model`

## Requirements
- R1: A processor strobe (`adsp_n` low) with `ce1_n` low, `ce2` high and `ce3_n` low loads `addr` and performs a read, even when `gw_n` or the byte-write controls request a write.
- R2: When `ce1_n` is high the processor strobe is ignored. `ce2` and `ce3_n` matter only in cycles where a strobe is taken. A taken strobe with any enable inactive is a deselect, which ends the burst. A controller strobe (`adsc_n` low) with all three enables active loads `addr` and performs a read or a write.
- R3: The write decode works as follows. `gw_n` low writes all lanes. Otherwise, `bw_n` low writes exactly the lanes whose `lane_n` bit is 0, where lane k is `dq_in[8k+7:8k]`. `bw_n` low with all `lane_n` bits high is a read.
- R4: A write cycle never drives the outputs: `dq_en` stays low for it. A read cycle drives all four lanes whatever the byte enables are.
- R5: With both strobes high, `adv_n` low and a burst active, the cycle uses the next burst address. Only the low two address bits change. Linear order (`burst_linear`=1) adds the beat count modulo 4. Interleaved order XORs the beat count into the start address. The fifth beat returns to the start address. Continuation cycles may be reads or writes.
- R6: With both strobes high and `adv_n` high, the burst is suspended: the cycle reuses the current address, either as a read or as a write.
- R7: With `pipe_mode`=0 (flow-through), read data is valid after the same edge that samples the read. With `pipe_mode`=1 (pipelined), it appears one edge later.
- R8: `oe_n` high forces `dq_en` low at once, without a clock. A read performed with `oe_n` high still advances the burst, so a continuation write can follow it directly.
- R9: If `sleep` is high at two consecutive edges, the operations sampled at those two edges still execute, and the device is asleep from then on. While asleep, all inputs except `sleep` are ignored, `dq_en` is low and the array contents are kept.
- R10: The edge that samples `sleep` low during sleep starts a recovery of `REC_CYC` edges. During recovery, reads and deselects work, but a write request is not performed and `wr_dropped` is high for the following cycle.
- R11: After reset, `dq_en` and `wr_dropped` are low and no burst is active. A continuation cycle without an active burst does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address |
| ce1_n | input | 1 | Chip enable 1, active low, also masks the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through reads |
| burst_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Sleep request, active high |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, zero when not driven |
| dq_en | output | 1 | Output drivers on |
| wr_dropped | output | 1 | A write was refused during sleep recovery |

## Verification
Single accesses are run in both read modes. Comparing when data first appears after a read tells flow-through latency from pipelined latency. Partial byte-write masks, a byte-write with no lanes selected and global writes that conflict with the lane bits separate the lane decode from the global path. Bursts are started at unaligned addresses in both orders and run past the fourth beat. They are mixed with suspends, with continuation cycles whose enables or processor strobe would otherwise matter, and with a dummy read under a high output enable followed by a write. These cases separate advance, wrap and masking. Sleep cycles place writes on both entry edges, during sleep and during recovery. This shows which edges still execute and that the contents survive.

// File: rtl/sbsram_pkg.sv
// Shared types for the synchronous burst RAM model.
// Assumes nothing beyond the 2-bit burst width used by every instance.
package sbsram_pkg;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        SLP_RUN     = 2'd0,
        SLP_ENTER   = 2'd1,
        SLP_ASLEEP  = 2'd2,
        SLP_RECOVER = 2'd3
    } slp_state_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_DESEL = 2'd3
    } op_e;
endpackage

// File: rtl/sbsram_burst.sv
// Burst address unit: holds the loaded address and a beat counter.
// Produces the address used in the current cycle. Only the low BURST_W
// bits walk, in linear (add) or interleaved (xor) order.
// Assumes ADDR_W > BURST_W.
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              adv,
    input  logic              linear,
    output logic [ADDR_W-1:0] eff_addr
);
    logic [ADDR_W-1:BURST_W] hi_q;
    logic [BURST_W-1:0]      base_q;
    logic [BURST_W-1:0]      cnt_q;
    logic [BURST_W-1:0]      cnt_use;
    logic [BURST_W-1:0]      low;

    // Address of this cycle: a new load, or the held burst stepped or not.
    always_comb begin
        cnt_use  = cnt_q + {{(BURST_W-1){1'b0}}, adv};
        low      = linear ? (base_q + cnt_use) : (base_q ^ cnt_use);
        eff_addr = load ? load_addr : {hi_q, low};
    end

    // Burst registers: reload on a strobe, otherwise keep the stepped count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (step_en) begin
            if (load) begin
                hi_q   <= load_addr[ADDR_W-1:BURST_W];
                base_q <= load_addr[BURST_W-1:0];
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_use;
            end
        end
    end
endmodule

// File: rtl/sbsram_wrdec.sv
// Write decode: turns global write, byte-write and lane enables into a
// per-lane write mask. Global write wins over the byte controls.
module sbsram_wrdec #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_we,
    output logic             wr_req
);
    // Lane mask with global priority; an empty mask means a read.
    always_comb begin
        if (!gw_n)      lane_we = '1;
        else if (!bw_n) lane_we = ~lane_n;
        else            lane_we = '0;
        wr_req = |lane_we;
    end
endmodule

// File: rtl/sbsram_array.sv
// Storage array: one memory per byte lane, written per lane mask.
// Reads are synchronous into a data register that holds between reads.
// Assumes read and write never happen in the same cycle.
module sbsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    re,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        // One lane: masked write, registered read.
        always_ff @(posedge clk) begin
            if (we && lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
            if (re)               rd_q      <= mem[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/sbsram_sleep.sv
// Sleep controller: sleep must be seen at two edges before the device
// sleeps. Wake-up passes through REC_CYC recovery edges.
// Assumes REC_CYC >= 1.
module sbsram_sleep
    import sbsram_pkg::*;
#(
    parameter int REC_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep,
    output slp_state_e state,
    output logic       ops_en,
    output logic       in_rec
);
    localparam int CW = $clog2(REC_CYC + 1);

    slp_state_e    st_q;
    logic [CW-1:0] cnt_q;

    // Sleep entry, stay and recovery sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SLP_RUN;
            cnt_q <= '0;
        end else begin
            case (st_q)
                SLP_RUN:    if (sleep) st_q <= SLP_ENTER;
                SLP_ENTER:  st_q <= sleep ? SLP_ASLEEP : SLP_RUN;
                SLP_ASLEEP: if (!sleep) begin
                    st_q  <= SLP_RECOVER;
                    cnt_q <= CW'(REC_CYC - 1);
                end
                default: begin
                    if (cnt_q == '0) st_q <= SLP_RUN;
                    else             cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    assign state  = st_q;
    assign ops_en = (st_q != SLP_ASLEEP);
    assign in_rec = (st_q == SLP_RECOVER);
endmodule

// File: rtl/sbsram_model.sv
// Synchronous burst RAM top. Decodes the two strobes and the enables into
// one operation per cycle, drives the burst unit and the array, and keeps
// a two-stage read path from which pipe_mode picks the tap.
// The output enable gates the drivers asynchronously.
// Assumes the inputs are synchronous to clk, except oe_n.
module sbsram_model
    import sbsram_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 8,
    parameter int REC_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bw_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    oe_n,
    input  logic                    pipe_mode,
    input  logic                    burst_linear,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_en,
    output logic                    wr_dropped
);
    localparam int DATA_W = LANES * LANE_W;

    slp_state_e         slp_state;
    logic               ops_en;
    logic               in_rec;
    logic [LANES-1:0]   lane_we;
    logic               wr_req;
    logic               act_q;
    op_e                op;
    logic               load;
    logic               adv_step;
    logic               drop;
    logic               op_wr;
    logic               op_rd;
    logic               step_en;
    logic [ADDR_W-1:0]  eff_addr;
    logic [DATA_W-1:0]  rdata;
    logic               s1_v;
    logic               s2_v;
    logic [DATA_W-1:0]  s2_d;
    logic               drop_q;
    logic               out_v;
    logic [DATA_W-1:0]  out_d;

    sbsram_sleep #(.REC_CYC(REC_CYC)) u_sleep (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .state  (slp_state),
        .ops_en (ops_en),
        .in_rec (in_rec)
    );

    sbsram_wrdec #(.LANES(LANES)) u_wrdec (
        .gw_n    (gw_n),
        .bw_n    (bw_n),
        .lane_n  (lane_n),
        .lane_we (lane_we),
        .wr_req  (wr_req)
    );

    // Cycle decode: processor strobe first, then controller strobe, then burst.
    always_comb begin
        op       = OP_IDLE;
        load     = 1'b0;
        adv_step = 1'b0;
        drop     = 1'b0;
        if (!adsp_n && !ce1_n) begin
            if (ce2 && !ce3_n) begin
                load = 1'b1;
                op   = OP_READ;
            end else begin
                op   = OP_DESEL;
            end
        end else if (!adsc_n) begin
            if (!ce1_n && ce2 && !ce3_n) begin
                load = 1'b1;
                op   = wr_req ? OP_WRITE : OP_READ;
            end else begin
                op   = OP_DESEL;
            end
        end else if (act_q) begin
            adv_step = !adv_n;
            op       = wr_req ? OP_WRITE : OP_READ;
        end
        if (!ops_en) begin
            op       = OP_IDLE;
            load     = 1'b0;
            adv_step = 1'b0;
        end
        if (in_rec && op == OP_WRITE) begin
            drop = 1'b1;
            op   = OP_IDLE;
        end
    end

    assign op_wr   = (op == OP_WRITE);
    assign op_rd   = (op == OP_READ);
    assign step_en = op_wr || op_rd || drop;

    // Burst activity: set by any load, cleared by a deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)              act_q <= 1'b0;
        else if (load && ops_en) act_q <= 1'b1;
        else if (op == OP_DESEL) act_q <= 1'b0;
    end

    sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .load      (load),
        .load_addr (addr),
        .adv       (adv_step),
        .linear    (burst_linear),
        .eff_addr  (eff_addr)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .addr    (eff_addr),
        .we      (op_wr),
        .lane_we (lane_we),
        .wdata   (dq_in),
        .re      (op_rd),
        .rdata   (rdata)
    );

    // Read path valids, the pipelined data stage and the drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s2_v   <= 1'b0;
            s2_d   <= '0;
            drop_q <= 1'b0;
        end else begin
            s1_v   <= op_rd;
            s2_v   <= s1_v && ops_en;
            s2_d   <= rdata;
            drop_q <= drop;
        end
    end

    // Output tap choice and asynchronous driver gating.
    always_comb begin
        out_v  = pipe_mode ? s2_v : s1_v;
        out_d  = pipe_mode ? s2_d : rdata;
        dq_en  = out_v && !oe_n && (slp_state != SLP_ASLEEP);
        dq_out = dq_en ? out_d : '0;
    end

    assign wr_dropped = drop_q;
endmodule

// File: rtl/sbsram_checker.sv
// Property checker for sbsram_model, bound to every instance.
// Watches decoded operations, the sleep state and the output drivers.
module sbsram_checker
    import sbsram_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       adsp_n,
    input logic       ce1_n,
    input logic       pipe_mode,
    input logic       sleep,
    input logic       dq_en,
    input logic       wr_dropped,
    input logic       op_wr,
    input logic       op_rd,
    input slp_state_e slp_state
);
    p_psp_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce1_n) |-> !op_wr);

    p_write_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && !pipe_mode) |=> (pipe_mode || !dq_en));

    p_flow_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_en && !pipe_mode && $past(rst_n)) |-> $past(op_rd));

    p_pipe_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_en && pipe_mode && $past(rst_n) && $past(rst_n, 2)) |-> $past(op_rd, 2));

    p_sleep_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slp_state == SLP_ASLEEP && $past(slp_state) != SLP_ASLEEP)
            |-> ($past(slp_state) == SLP_ENTER && $past(sleep)));

    p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slp_state == SLP_ASLEEP) |-> (!op_wr && !op_rd && !dq_en));

    p_rec_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slp_state == SLP_RECOVER) |-> !op_wr);

    p_drop_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dropped && $past(rst_n)) |-> ($past(slp_state) == SLP_RECOVER));
endmodule

bind sbsram_model sbsram_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adsp_n     (adsp_n),
    .ce1_n      (ce1_n),
    .pipe_mode  (pipe_mode),
    .sleep      (sleep),
    .dq_en      (dq_en),
    .wr_dropped (wr_dropped),
    .op_wr      (op_wr),
    .op_rd      (op_rd),
    .slp_state  (slp_state)
);

// File: tb/sbsram_model_bench.sv
// Directed bench for sbsram_model with a scoreboard memory.
// Inputs change 1 ns after a rising edge; outputs are checked at that point.
module sbsram_model_bench;
    localparam int CLK_P = 10;
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int REC   = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bw_n;
    logic [3:0]    lane_n;
    logic          oe_n, pipe_mode, burst_linear, sleep;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out;
    logic          dq_en;
    logic          wr_dropped;

    logic [DW-1:0] sb [256];
    int            n_tests = 0;
    int            n_fail  = 0;

    sbsram_model #(.ADDR_W(AW), .LANES(4), .LANE_W(8), .REC_CYC(REC)) u_sbsram_model (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bw_n(bw_n),
        .lane_n(lane_n), .oe_n(oe_n), .pipe_mode(pipe_mode), .burst_linear(burst_linear),
        .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_en(dq_en), .wr_dropped(wr_dropped)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bw_n = 1'b1; lane_n = 4'hF;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    endtask

    function automatic logic [AW-1:0] baddr(input logic [AW-1:0] s, input int i, input logic lin);
        logic [1:0] k;
        k = 2'(i);
        return {s[AW-1:2], lin ? (s[1:0] + k) : (s[1:0] ^ k)};
    endfunction

    // Deselect through the controller strobe with ce1_n high.
    task automatic desel();
        idle();
        adsc_n = 1'b0; ce1_n = 1'b1;
        tick();
        idle();
    endtask

    // Controller-strobe write; global or per lane. Updates the scoreboard.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic glob, input logic [3:0] ln);
        idle();
        addr = a; dq_in = d; adsc_n = 1'b0;
        if (glob) gw_n = 1'b0;
        else begin bw_n = 1'b0; lane_n = ln; end
        tick();
        for (int k = 0; k < 4; k++)
            if (glob || !ln[k]) sb[a][k*8 +: 8] = d[k*8 +: 8];
        idle();
    endtask

    // Single controller-strobe read, checked with the current mode latency.
    task automatic rd(input logic [AW-1:0] a, input string req);
        desel();
        addr = a; adsc_n = 1'b0;
        tick();
        idle();
        if (!pipe_mode) begin
            chk(req, {31'd0, dq_en}, 32'd1);
            chk(req, dq_out, sb[a]);
        end else begin
            chk(req, {31'd0, dq_en}, 32'd0);
        end
        desel();
        if (pipe_mode) begin
            chk(req, {31'd0, dq_en}, 32'd1);
            chk(req, dq_out, sb[a]);
        end
    endtask

    task automatic t_reset();
        chk("R11 reset dq_en", {31'd0, dq_en}, 32'd0);
        chk("R11 reset wr_dropped", {31'd0, wr_dropped}, 32'd0);
        idle(); adv_n = 1'b0; pipe_mode = 1'b0;
        tick();
        chk("R11 continue without burst", {31'd0, dq_en}, 32'd0);
        idle();
    endtask

    task automatic t_single();
        for (int m = 0; m < 2; m++) begin
            pipe_mode = m[0];
            wr(8'h20 + 8'(m), 32'hCAFE0000 + 32'(m), 1'b1, 4'hF);
            chk("R4 write keeps drivers off", {31'd0, dq_en}, 32'd0);
            rd(8'h20 + 8'(m), "R7 single read latency");
            rd(8'h05, "R7 preloaded read");
        end
    endtask

    task automatic t_bytes();
        pipe_mode = 1'b0;
        wr(8'h30, 32'h11223344, 1'b1, 4'hF);
        wr(8'h30, 32'hAABBCCDD, 1'b0, 4'b1010);
        rd(8'h30, "R3 partial lanes 0 and 2");
        wr(8'h30, 32'h55555555, 1'b0, 4'b1111);
        rd(8'h30, "R3 byte write with no lane is a read");
        idle(); addr = 8'h30; adsc_n = 1'b0; bw_n = 1'b0; lane_n = 4'hF; dq_in = 32'h0;
        tick();
        chk("R4 read drives all lanes", dq_out, sb[8'h30]);
        idle();
        idle(); addr = 8'h31; adsc_n = 1'b0; gw_n = 1'b0; bw_n = 1'b1; lane_n = 4'b1110;
        dq_in = 32'h9ABCDEF0;
        tick();
        sb[8'h31] = 32'h9ABCDEF0;
        idle();
        rd(8'h31, "R3 global write overrides lanes");
    endtask

    task automatic t_psp();
        pipe_mode = 1'b0;
        desel();
        addr = 8'h07; adsp_n = 1'b0; gw_n = 1'b0; dq_in = 32'hDEADBEEF;
        tick();
        idle();
        chk("R1 processor strobe reads", dq_out, sb[8'h07]);
        rd(8'h07, "R1 processor strobe did not write");
    endtask

    task automatic t_burst(input logic lin, input logic pm, input logic [AW-1:0] s);
        pipe_mode = pm; burst_linear = lin;
        desel();
        for (int i = 0; i < 5; i++) begin
            idle();
            if (i == 0) begin addr = s; adsc_n = 1'b0; end
            else adv_n = 1'b0;
            tick();
            if (!pm) chk("R5 burst beat", dq_out, sb[baddr(s, i, lin)]);
            else if (i > 0) chk("R5 burst beat pipelined", dq_out, sb[baddr(s, i - 1, lin)]);
        end
        desel();
        if (pm) chk("R5 burst wrap pipelined", dq_out, sb[s]);
    endtask

    task automatic t_suspend();
        pipe_mode = 1'b0; burst_linear = 1'b1;
        desel();
        addr = 8'h09; adsc_n = 1'b0;
        tick();
        idle(); adv_n = 1'b1;
        tick();
        chk("R6 suspend read repeats", dq_out, sb[8'h09]);
        idle(); gw_n = 1'b0; dq_in = 32'h0BADF00D;
        tick();
        sb[8'h09] = 32'h0BADF00D;
        idle(); adv_n = 1'b0; gw_n = 1'b0; dq_in = 32'h600DF00D;
        tick();
        sb[8'h0A] = 32'h600DF00D;
        idle();
        rd(8'h09, "R6 suspend write same address");
        rd(8'h0A, "R5 continuation write");
    endtask

    task automatic t_enables();
        pipe_mode = 1'b0; burst_linear = 1'b0;
        desel();
        addr = 8'h0D; adsc_n = 1'b0;
        tick();
        idle(); adsp_n = 1'b0; ce1_n = 1'b1; addr = 8'h44; adv_n = 1'b0;
        tick();
        chk("R2 masked processor strobe continues", dq_out, sb[baddr(8'h0D, 1, 1'b0)]);
        idle(); ce2 = 1'b0; ce3_n = 1'b1; adv_n = 1'b0;
        tick();
        chk("R2 enables ignored without strobe", dq_out, sb[baddr(8'h0D, 2, 1'b0)]);
        idle(); adsc_n = 1'b0; ce3_n = 1'b1; addr = 8'h01;
        tick();
        chk("R2 strobe with ce3_n high deselects", {31'd0, dq_en}, 32'd0);
        idle(); adv_n = 1'b0;
        tick();
        chk("R11 burst ended by deselect", {31'd0, dq_en}, 32'd0);
        idle();
    endtask

    task automatic t_oe();
        pipe_mode = 1'b0; burst_linear = 1'b1;
        desel();
        oe_n = 1'b1; addr = 8'h10; adsc_n = 1'b0;
        tick();
        idle();
        chk("R8 oe_n high drivers off", {31'd0, dq_en}, 32'd0);
        oe_n = 1'b0;
        #1;
        chk("R8 oe_n low drivers on without clock", dq_out, sb[8'h10]);
        oe_n = 1'b1;
        adv_n = 1'b0;
        tick();
        idle(); adv_n = 1'b0; gw_n = 1'b0; dq_in = 32'h7E57DA7A;
        tick();
        sb[8'h12] = 32'h7E57DA7A;
        idle(); oe_n = 1'b0;
        rd(8'h12, "R8 dummy read advanced then write");
    endtask

    task automatic t_sleep();
        pipe_mode = 1'b0;
        desel();
        sleep = 1'b1;
        wr(8'h40, 32'hA1A1A1A1, 1'b1, 4'hF);
        wr(8'h41, 32'hB2B2B2B2, 1'b1, 4'hF);
        idle(); addr = 8'h40; adsc_n = 1'b0; gw_n = 1'b0; dq_in = 32'hFFFF0000;
        tick();
        idle(); addr = 8'h41; adsc_n = 1'b0;
        tick();
        chk("R9 asleep read has drivers off", {31'd0, dq_en}, 32'd0);
        sleep = 1'b0;
        idle();
        tick();
        addr = 8'h41; adsc_n = 1'b0; gw_n = 1'b0; dq_in = 32'h12121212;
        tick();
        idle();
        chk("R10 dropped write flagged", {31'd0, wr_dropped}, 32'd1);
        addr = 8'h40; adsc_n = 1'b0;
        tick();
        idle();
        chk("R9 contents kept, sleep write ignored", dq_out, sb[8'h40]);
        chk("R10 flag lasts one cycle", {31'd0, wr_dropped}, 32'd0);
        addr = 8'h41; adsc_n = 1'b0;
        tick();
        idle();
        chk("R10 recovery write not performed", dq_out, sb[8'h41]);
        desel(); desel(); desel();
        wr(8'h41, 32'h34343434, 1'b1, 4'hF);
        chk("R10 write after recovery not flagged", {31'd0, wr_dropped}, 32'd0);
        rd(8'h41, "R10 write works after recovery");
    endtask

    initial begin
        #(CLK_P * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle();
        addr = '0; dq_in = '0; oe_n = 1'b0; pipe_mode = 1'b1; burst_linear = 1'b1; sleep = 1'b0;
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) sb[i] = 'x;
        tick(); tick();
        rst_n = 1'b1;
        t_reset();
        for (int i = 0; i < 32; i++)
            wr(8'(i), {8'(i), ~8'(i), 8'(i) ^ 8'h5A, 8'hC3 + 8'(i)}, 1'b1, 4'hF);
        t_single();
        t_bytes();
        t_psp();
        t_burst(1'b1, 1'b0, 8'h06);
        t_burst(1'b0, 1'b0, 8'h0B);
        t_burst(1'b1, 1'b1, 8'h17);
        t_burst(1'b0, 1'b1, 8'h1D);
        t_suspend();
        t_enables();
        t_oe();
        t_sleep();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule